// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block is the combinational hazard logic of a five-stage, in-order 32-bit pipeline. For every source operand it decides whether the value read from the register file is stale and, when it is, substitutes the result that an older instruction still holds in the execute/memory or memory/writeback pipeline register. The same selection serves two consumers: the operands already latched for the instruction now in execute, and the operands being read by the instruction in decode.

The unit also detects the one hazard that forwarding cannot cover. That hazard is a load in execute whose data is not yet available, followed in decode by an instruction that needs it. In that case it freezes fetch and decode for one cycle and turns the entry written into the decode/execute register into a bubble. The bubble carries neither a valid bit nor a register-write flag, so it can never later pose as a forwarding source. Outputs follow the inputs within the same cycle, with no registers inside.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A stage is a forwarding source for an operand only when that stage is valid, its write flag is 1, its destination is nonzero, and its destination equals the operand's source address.
- R2: When only the memory/writeback stage qualifies under R1, its result replaces the register-file value.
- R3: When both the execute/memory and the memory/writeback stages qualify for the same operand, the execute/memory result is used.
- R4: When no stage qualifies, the operand equals the register-file (or latched) value; source address 0 therefore never receives a forwarded value, even if a stage writes destination 0.
- R5: Decode operands (`dec_op1`, `dec_op2`) use exactly the same selection as execute operands, applied to the decode source addresses and register-file values.
- R6: `stall` is 1 when execute holds a valid load (`id_ex_valid`=1, `id_ex_is_load`=1), decode holds a valid instruction (`if_id_valid`=1), and the load destination equals a nonzero decode rs1.
- R7: A match between the load destination and a nonzero decode rs2 raises `stall` only when the decoded instruction is R-type, a store or a branch (`dec_is_rtype`, `dec_is_store` or `dec_is_branch` is 1); for any other class it has no effect.
- R8: While `stall` is 1, `bubble` is 1 and both `idex_valid_nxt` and `idex_wr_nxt` are 0; while `stall` is 0, `bubble` is 0, `idex_valid_nxt` equals `if_id_valid` and `idex_wr_nxt` equals `dec_wr` AND `if_id_valid`.
- R9: No stall is raised when the execute instruction is not a load, when execute is invalid, or when decode is invalid, regardless of address matches.
- R10: All outputs reflect the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_valid | input | 1 | Execute/memory register holds a live instruction |
| ex_mem_wr | input | 1 | That instruction writes a register |
| ex_mem_rd | input | RA | Its destination register |
| ex_mem_result | input | XLEN | Its result |
| mem_wb_valid | input | 1 | Memory/writeback register holds a live instruction |
| mem_wb_wr | input | 1 | That instruction writes a register |
| mem_wb_rd | input | RA | Its destination register |
| mem_wb_result | input | XLEN | Its result |
| id_ex_valid | input | 1 | Decode/execute register holds a live instruction |
| id_ex_is_load | input | 1 | That instruction is a load |
| id_ex_rd | input | RA | Its destination register |
| id_ex_rs1 | input | RA | Its first source address |
| id_ex_rs2 | input | RA | Its second source address |
| id_ex_rs1_val | input | XLEN | First operand value latched at decode |
| id_ex_rs2_val | input | XLEN | Second operand value latched at decode |
| if_id_valid | input | 1 | Fetch/decode register holds a live instruction |
| dec_rs1 | input | RA | Decode first source address |
| dec_rs2 | input | RA | Decode second source address |
| dec_rs1_rf | input | XLEN | Register-file value for decode rs1 |
| dec_rs2_rf | input | XLEN | Register-file value for decode rs2 |
| dec_is_rtype | input | 1 | Decoded instruction is register-register |
| dec_is_store | input | 1 | Decoded instruction is a store |
| dec_is_branch | input | 1 | Decoded instruction is a conditional branch |
| dec_wr | input | 1 | Decoded instruction writes a register |
| ex_op1 | output | XLEN | Forwarded first operand for execute |
| ex_op2 | output | XLEN | Forwarded second operand for execute |
| dec_op1 | output | XLEN | Forwarded first operand for decode |
| dec_op2 | output | XLEN | Forwarded second operand for decode |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Load a bubble into decode/execute |
| idex_valid_nxt | output | 1 | Valid bit to load into decode/execute |
| idex_wr_nxt | output | 1 | Write flag to load into decode/execute |

## Verification
Forwarding is driven with a single qualifying source in each stage, then with each of the four qualifying conditions removed one at a time, which separates a correct AND of all four from a check that omits any one of them. Back-to-back writes to the same register put both stages on one address, which distinguishes the intended priority from its reverse, and writes to x0 with a zero source address expose a missing zero-register exclusion. For stalls, a load followed by a store consuming the load result as rs2 is contrasted with an immediate-class instruction that merely carries the same rs2 field, and the invalid-decode, invalid-execute and non-load cases show that the stall is gated correctly; the bubble's valid and write outputs are checked in each case.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int XLEN = 32,
  parameter int RA   = 5
) (
  input  logic            ex_mem_valid,
  input  logic            ex_mem_wr,
  input  logic [RA-1:0]   ex_mem_rd,
  input  logic [XLEN-1:0] ex_mem_result,
  input  logic            mem_wb_valid,
  input  logic            mem_wb_wr,
  input  logic [RA-1:0]   mem_wb_rd,
  input  logic [XLEN-1:0] mem_wb_result,
  input  logic            id_ex_valid,
  input  logic            id_ex_is_load,
  input  logic [RA-1:0]   id_ex_rd,
  input  logic [RA-1:0]   id_ex_rs1,
  input  logic [RA-1:0]   id_ex_rs2,
  input  logic [XLEN-1:0] id_ex_rs1_val,
  input  logic [XLEN-1:0] id_ex_rs2_val,
  input  logic            if_id_valid,
  input  logic [RA-1:0]   dec_rs1,
  input  logic [RA-1:0]   dec_rs2,
  input  logic [XLEN-1:0] dec_rs1_rf,
  input  logic [XLEN-1:0] dec_rs2_rf,
  input  logic            dec_is_rtype,
  input  logic            dec_is_store,
  input  logic            dec_is_branch,
  input  logic            dec_wr,
  output logic [XLEN-1:0] ex_op1,
  output logic [XLEN-1:0] ex_op2,
  output logic [XLEN-1:0] dec_op1,
  output logic [XLEN-1:0] dec_op2,
  output logic            stall,
  output logic            bubble,
  output logic            idex_valid_nxt,
  output logic            idex_wr_nxt
);

  logic em_live, wb_live;
  assign em_live = ex_mem_valid && ex_mem_wr && (ex_mem_rd != '0);
  assign wb_live = mem_wb_valid && mem_wb_wr && (mem_wb_rd != '0);

  function automatic logic [XLEN-1:0] pick(input logic [RA-1:0] src,
                                           input logic [XLEN-1:0] own);
    if (em_live && ex_mem_rd == src)      return ex_mem_result;
    else if (wb_live && mem_wb_rd == src) return mem_wb_result;
    else                                  return own;
  endfunction

  assign ex_op1  = pick(id_ex_rs1, id_ex_rs1_val);
  assign ex_op2  = pick(id_ex_rs2, id_ex_rs2_val);
  assign dec_op1 = pick(dec_rs1, dec_rs1_rf);
  assign dec_op2 = pick(dec_rs2, dec_rs2_rf);

  logic hit1, hit2, rs2_read, load_use;
  assign hit1     = (dec_rs1 != '0) && (id_ex_rd == dec_rs1);
  assign hit2     = (dec_rs2 != '0) && (id_ex_rd == dec_rs2);
  assign rs2_read = dec_is_rtype || dec_is_store || dec_is_branch;
  assign load_use = id_ex_valid && id_ex_is_load && if_id_valid &&
                    (hit1 || (hit2 && rs2_read));

  assign stall          = load_use;
  assign bubble         = load_use;
  assign idex_valid_nxt = if_id_valid && !load_use;
  assign idex_wr_nxt    = if_id_valid && dec_wr && !load_use;

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int XLEN = 32,
  parameter int RA   = 5
) (
  input logic            ex_mem_valid,
  input logic            ex_mem_wr,
  input logic [RA-1:0]   ex_mem_rd,
  input logic [XLEN-1:0] ex_mem_result,
  input logic            id_ex_valid,
  input logic            id_ex_is_load,
  input logic [RA-1:0]   id_ex_rd,
  input logic [RA-1:0]   id_ex_rs1,
  input logic [XLEN-1:0] id_ex_rs1_val,
  input logic            if_id_valid,
  input logic [RA-1:0]   dec_rs1,
  input logic [RA-1:0]   dec_rs2,
  input logic [XLEN-1:0] dec_rs1_rf,
  input logic            dec_is_rtype,
  input logic            dec_is_store,
  input logic            dec_is_branch,
  input logic [XLEN-1:0] ex_op1,
  input logic [XLEN-1:0] dec_op1,
  input logic            stall,
  input logic            bubble,
  input logic            idex_valid_nxt,
  input logic            idex_wr_nxt
);
  logic known;
  assign known = !$isunknown({ex_mem_valid, ex_mem_wr, ex_mem_rd, ex_mem_result,
                              id_ex_valid, id_ex_is_load, id_ex_rd, id_ex_rs1,
                              id_ex_rs1_val, if_id_valid, dec_rs1, dec_rs2,
                              dec_rs1_rf, dec_is_rtype, dec_is_store, dec_is_branch,
                              ex_op1, dec_op1, stall, bubble, idex_valid_nxt, idex_wr_nxt});

  always_comb begin
    if (known) begin
      if (ex_mem_valid && ex_mem_wr && ex_mem_rd != '0 && ex_mem_rd == id_ex_rs1)
        a_r3_newest_wins: assert (ex_op1 == ex_mem_result);
      if (id_ex_rs1 == '0)
        a_r4_zero_reg_plain: assert (ex_op1 == id_ex_rs1_val);
      if (dec_rs1 == '0)
        a_r5_dec_zero_plain: assert (dec_op1 == dec_rs1_rf);
      if (id_ex_valid && id_ex_is_load && if_id_valid && dec_rs1 != '0 && id_ex_rd == dec_rs1)
        a_r6_rs1_load_stall: assert (stall);
      if (stall && !(dec_rs1 != '0 && id_ex_rd == dec_rs1))
        a_r7_rs2_class_gate: assert ((dec_is_rtype || dec_is_store || dec_is_branch)
                                     && dec_rs2 != '0 && id_ex_rd == dec_rs2);
      a_r8_bubble_clean: assert (stall == bubble && (!stall || (!idex_valid_nxt && !idex_wr_nxt)));
      if (!(id_ex_valid && id_ex_is_load && if_id_valid))
        a_r9_no_spurious_stall: assert (!stall);
    end
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.XLEN(XLEN), .RA(RA)) u_chk (
  .ex_mem_valid(ex_mem_valid), .ex_mem_wr(ex_mem_wr), .ex_mem_rd(ex_mem_rd),
  .ex_mem_result(ex_mem_result), .id_ex_valid(id_ex_valid),
  .id_ex_is_load(id_ex_is_load), .id_ex_rd(id_ex_rd), .id_ex_rs1(id_ex_rs1),
  .id_ex_rs1_val(id_ex_rs1_val), .if_id_valid(if_id_valid), .dec_rs1(dec_rs1),
  .dec_rs2(dec_rs2), .dec_rs1_rf(dec_rs1_rf), .dec_is_rtype(dec_is_rtype),
  .dec_is_store(dec_is_store), .dec_is_branch(dec_is_branch), .ex_op1(ex_op1),
  .dec_op1(dec_op1), .stall(stall), .bubble(bubble),
  .idex_valid_nxt(idex_valid_nxt), .idex_wr_nxt(idex_wr_nxt)
);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;
  localparam int XLEN = 32;
  localparam int RA   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            ex_mem_valid, ex_mem_wr, mem_wb_valid, mem_wb_wr;
  logic [RA-1:0]   ex_mem_rd, mem_wb_rd, id_ex_rd, id_ex_rs1, id_ex_rs2, dec_rs1, dec_rs2;
  logic [XLEN-1:0] ex_mem_result, mem_wb_result, id_ex_rs1_val, id_ex_rs2_val;
  logic [XLEN-1:0] dec_rs1_rf, dec_rs2_rf;
  logic            id_ex_valid, id_ex_is_load, if_id_valid;
  logic            dec_is_rtype, dec_is_store, dec_is_branch, dec_wr;
  logic [XLEN-1:0] ex_op1, ex_op2, dec_op1, dec_op2;
  logic            stall, bubble, idex_valid_nxt, idex_wr_nxt;

  hazard_fwd_unit #(.XLEN(XLEN), .RA(RA)) u_hazard_fwd_unit (.*);

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    ex_mem_valid = 0; ex_mem_wr = 0; ex_mem_rd = 0; ex_mem_result = 32'hE000_0001;
    mem_wb_valid = 0; mem_wb_wr = 0; mem_wb_rd = 0; mem_wb_result = 32'hB000_0002;
    id_ex_valid = 0; id_ex_is_load = 0; id_ex_rd = 0;
    id_ex_rs1 = 0; id_ex_rs2 = 0; id_ex_rs1_val = 32'h1111_1111; id_ex_rs2_val = 32'h2222_2222;
    if_id_valid = 0; dec_rs1 = 0; dec_rs2 = 0;
    dec_rs1_rf = 32'h3333_3333; dec_rs2_rf = 32'h4444_4444;
    dec_is_rtype = 0; dec_is_store = 0; dec_is_branch = 0; dec_wr = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_idle();
    idle(); settle();
    chk("R4 idle ex_op1", ex_op1, 32'h1111_1111);
    chk("R4 idle dec_op2", dec_op2, 32'h4444_4444);
    chk("R9 idle stall", {31'd0, stall}, 0);
    chk("R8 idle bubble", {31'd0, bubble}, 0);
  endtask

  task automatic t_exmem();
    idle(); id_ex_rs1 = 5'd7; ex_mem_valid = 1; ex_mem_wr = 1; ex_mem_rd = 5'd7; settle();
    chk("R1 ex/mem forward", ex_op1, 32'hE000_0001);
    chk("R10 same-cycle op2 untouched", ex_op2, 32'h2222_2222);
    ex_mem_valid = 0; settle();
    chk("R1 invalid stage ignored", ex_op1, 32'h1111_1111);
    ex_mem_valid = 1; ex_mem_wr = 0; settle();
    chk("R1 no-write stage ignored", ex_op1, 32'h1111_1111);
    ex_mem_wr = 1; ex_mem_rd = 5'd8; settle();
    chk("R1 address mismatch ignored", ex_op1, 32'h1111_1111);
  endtask

  task automatic t_memwb();
    idle(); id_ex_rs2 = 5'd12; mem_wb_valid = 1; mem_wb_wr = 1; mem_wb_rd = 5'd12; settle();
    chk("R2 mem/wb forward op2", ex_op2, 32'hB000_0002);
    mem_wb_valid = 0; settle();
    chk("R2 invalid mem/wb ignored", ex_op2, 32'h2222_2222);
  endtask

  task automatic t_priority();
    idle(); id_ex_rs1 = 5'd5; id_ex_rs2 = 5'd5;
    ex_mem_valid = 1; ex_mem_wr = 1; ex_mem_rd = 5'd5;
    mem_wb_valid = 1; mem_wb_wr = 1; mem_wb_rd = 5'd5; settle();
    chk("R3 newer stage wins op1", ex_op1, 32'hE000_0001);
    chk("R3 newer stage wins op2", ex_op2, 32'hE000_0001);
    ex_mem_wr = 0; settle();
    chk("R3 falls back to mem/wb", ex_op1, 32'hB000_0002);
  endtask

  task automatic t_x0();
    idle(); id_ex_rs1 = 0; dec_rs2 = 0;
    ex_mem_valid = 1; ex_mem_wr = 1; ex_mem_rd = 0;
    mem_wb_valid = 1; mem_wb_wr = 1; mem_wb_rd = 0; settle();
    chk("R4 x0 ex operand not forwarded", ex_op1, 32'h1111_1111);
    chk("R4 x0 dec operand not forwarded", dec_op2, 32'h4444_4444);
  endtask

  task automatic t_decode();
    idle(); dec_rs1 = 5'd9; dec_rs2 = 5'd10;
    ex_mem_valid = 1; ex_mem_wr = 1; ex_mem_rd = 5'd9;
    mem_wb_valid = 1; mem_wb_wr = 1; mem_wb_rd = 5'd10; settle();
    chk("R5 dec op1 from ex/mem", dec_op1, 32'hE000_0001);
    chk("R5 dec op2 from mem/wb", dec_op2, 32'hB000_0002);
    mem_wb_rd = 5'd9; settle();
    chk("R5 dec priority", dec_op1, 32'hE000_0001);
    chk("R5 dec op2 fallback", dec_op2, 32'h4444_4444);
  endtask

  task automatic t_load_rs1();
    idle(); id_ex_valid = 1; id_ex_is_load = 1; id_ex_rd = 5'd2;
    if_id_valid = 1; dec_rs1 = 5'd2; dec_wr = 1; settle();
    chk("R6 load-use rs1 stall", {31'd0, stall}, 1);
    chk("R8 bubble asserted", {31'd0, bubble}, 1);
    chk("R8 bubble valid cleared", {31'd0, idex_valid_nxt}, 0);
    chk("R8 bubble write cleared", {31'd0, idex_wr_nxt}, 0);
    id_ex_rd = 0; dec_rs1 = 0; settle();
    chk("R6 x0 never stalls", {31'd0, stall}, 0);
    chk("R8 pass-through write", {31'd0, idex_wr_nxt}, 1);
    chk("R8 pass-through valid", {31'd0, idex_valid_nxt}, 1);
  endtask

  task automatic t_load_rs2();
    idle(); id_ex_valid = 1; id_ex_is_load = 1; id_ex_rd = 5'd6;
    if_id_valid = 1; dec_rs1 = 5'd1; dec_rs2 = 5'd6; dec_is_store = 1; settle();
    chk("R7 store uses load result rs2", {31'd0, stall}, 1);
    dec_is_store = 0; settle();
    chk("R7 immediate class ignores rs2", {31'd0, stall}, 0);
    dec_is_rtype = 1; settle();
    chk("R7 rtype rs2 stall", {31'd0, stall}, 1);
    dec_is_rtype = 0; dec_is_branch = 1; settle();
    chk("R7 branch rs2 stall", {31'd0, stall}, 1);
  endtask

  task automatic t_gating();
    idle(); id_ex_valid = 1; id_ex_is_load = 0; id_ex_rd = 5'd3;
    if_id_valid = 1; dec_rs1 = 5'd3; dec_wr = 1; settle();
    chk("R9 non-load no stall", {31'd0, stall}, 0);
    id_ex_is_load = 1; id_ex_valid = 0; settle();
    chk("R9 invalid execute no stall", {31'd0, stall}, 0);
    id_ex_valid = 1; if_id_valid = 0; settle();
    chk("R9 invalid decode no stall", {31'd0, stall}, 0);
    chk("R8 invalid decode no write", {31'd0, idex_wr_nxt}, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_exmem();
    t_memwb();
    t_priority();
    t_x0();
    t_decode();
    t_load_rs1();
    t_load_rs2();
    t_gating();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule